// File: doc/BRIEF.md
# Static Memory Bus Timing Sequencer

This block turns one host request into the control waveforms of a single access to an external asynchronous static memory. It drives an active-low chip select, a read strobe and a write strobe, plus byte-lane controls. When a request is accepted, a cycle counter starts at zero. Each control line is asserted over a window of that counter. The window starts at a programmed setup value and lasts a programmed number of pulse cycles. The access ends when the counter reaches a programmed total. Reads and writes have independent timing sets. Within each set, the chip select and the data strobe have their own windows.

An active-low wait input from the memory can be ignored, can freeze the whole access, or can stretch the controlling strobe at the end of its pulse. Byte lanes are driven either as byte-select lines alongside a common write strobe, or as one write strobe per lane. A width bit selects an 8-bit or a 16-bit external data bus. The host receives a one-cycle done pulse and, for reads, the data captured when the read strobe ends. The timing inputs and mode inputs must stay stable while an access is in progress. The wait input is treated as synchronous to the clock.

Top module: `smc_bus_seq`

## Requirements
- R1: After reset, the outputs are idle: chip select, read strobe, write strobe, every per-lane write strobe and every byte select are high, done is low and the data output enable is low. They stay in that state whenever no access is in progress.
- R2: The first cycle of an access is counter value 0. The chip select and the data strobe are each low from the cycle whose counter equals their setup value up to, but not including, the cycle whose counter equals setup plus pulse. The values come from the write set or the read set according to the request direction. A window that runs past the end of the access is cut off there. A read strobe and a write strobe are never low together.
- R3: Without stretching, done is high for exactly one cycle, the cycle whose index equals the total count. The counter stays below the total during the access. A total of 0 acts as 1.
- R4: With wait mode 2'b00 (ignore) or 2'b01 (reserved), a low wait input changes no edge of any control line and does not change the done cycle.
- R5: With wait mode 2'b10 (freeze), every cycle in which wait is low holds the counter and all control lines. The access then resumes from the same count. Every later edge moves by the number of frozen cycles.
- R6: With wait mode 2'b11 (ready), wait is examined only in the last cycle of the controlling strobe pulse (counter = setup + pulse − 1 of the data strobe). While wait is low there, the strobe stays low and the counter holds. Later edges move by the number of extra cycles.
- R7: With lane style 0 (byte select), writes use the common write strobe and reads use the read strobe. Byte select i is low for the whole access exactly when byte enable i is set. The per-lane write strobes stay high.
- R8: With lane style 1 (per-byte write), a write drives the write strobe of lane i only when byte enable i is set, with data-strobe timing, and the common write strobe stays high. A read uses only chip select and the read strobe, with every byte select high.
- R9: With bus16 = 0 (8-bit bus), lane 1 is never enabled. Write data drives only bits 7:0, with bits 15:8 at zero. Read data returns bits 7:0 of the bus, with the upper byte zero.
- R10: With bus16 = 1, a write drives all 16 request data bits while the strobe is low. A read returns the 16 bus bits present in the last cycle before the read strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request, accepted when no access is in progress |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit i = lane i |
| rsp_done | output | 1 | One-cycle pulse after the last access cycle |
| rsp_rdata | output | 16 | Captured read data |
| busy | output | 1 | An access is in progress |
| wr_cs_setup | input | 6 | Write chip-select setup |
| wr_cs_pulse | input | 7 | Write chip-select pulse |
| wr_st_setup | input | 6 | Write strobe setup |
| wr_st_pulse | input | 7 | Write strobe pulse |
| wr_total | input | 9 | Write total cycles |
| rd_cs_setup | input | 6 | Read chip-select setup |
| rd_cs_pulse | input | 7 | Read chip-select pulse |
| rd_st_setup | input | 6 | Read strobe setup |
| rd_st_pulse | input | 7 | Read strobe pulse |
| rd_total | input | 9 | Read total cycles |
| wait_mode | input | 2 | 00 ignore, 01 reserved, 10 freeze, 11 ready |
| lane_style | input | 1 | 0 byte select, 1 per-byte write strobes |
| bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| mem_addr | output | ADDR_W | Address held for the access |
| mem_dout | output | 16 | Write data toward memory |
| mem_doe | output | 1 | Data output enable during a write |
| mem_din | input | 16 | Data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Common write strobe, active low |
| mem_wr_n | output | 2 | Per-lane write strobes, active low |
| mem_bs_n | output | 2 | Byte selects, active low |
| mem_wait_n | input | 1 | Wait from memory, active low |

## Verification
Accesses run with several setup, pulse and total settings. These include a chip-select window longer than the access and a total of zero. They tell correct window edges apart from off-by-one errors and from missing end-of-access clipping. The same wait pattern, wait held low over many cycles, is applied in the ignore, reserved, freeze and ready modes. It tells the modes apart: ignore and reserved show no shift, freeze shifts every edge after the first low cycle, and ready shifts only the edges after the strobe pulse ends. A short wait that ends before the pulse end confirms that ready mode ignores early lows. Reads and writes with partial byte enables, in both lane styles and both bus widths, show which lines each combination may drive.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;
    localparam int SETUP_W = 6;
    localparam int PULSE_W = 7;
    localparam int TOTAL_W = 9;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANES * 8;
    localparam int NUM_CH  = 2;          // 0: chip select, 1: data strobe
    localparam int CH_CS   = 0;
    localparam int CH_ST   = 1;

    typedef enum logic [1:0] {
        WAIT_IGNORE = 2'b00,
        WAIT_RSVD   = 2'b01,
        WAIT_FREEZE = 2'b10,
        WAIT_READY  = 2'b11
    } wait_mode_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [PULSE_W-1:0] pulse;
    } win_t;

    // End of a window (first count outside it), one bit wider than the counter.
    function automatic logic [TOTAL_W:0] win_end(input win_t w);
        return (TOTAL_W+1)'(w.setup) + (TOTAL_W+1)'(w.pulse);
    endfunction

    function automatic logic in_window(input logic [TOTAL_W-1:0] c, input win_t w);
        logic [TOTAL_W:0] cx;
        cx = {1'b0, c};
        return (cx >= (TOTAL_W+1)'(w.setup)) && (cx < win_end(w));
    endfunction
endpackage

// File: rtl/smc_cycle_ctr.sv
module smc_cycle_ctr
    import smc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               hold,
    input  logic [TOTAL_W-1:0] total,
    output logic               active_q,
    output logic               active_d,
    output logic [TOTAL_W-1:0] cnt_q,
    output logic [TOTAL_W-1:0] cnt_d,
    output logic               done_q
);
    logic [TOTAL_W-1:0] total_eff;
    logic               last;

    assign total_eff = (total == '0) ? TOTAL_W'(1) : total;
    assign last      = (cnt_q == total_eff - 1'b1);

    always_comb begin
        active_d = active_q;
        cnt_d    = cnt_q;
        if (!active_q) begin
            active_d = start;
            cnt_d    = '0;
        end else if (!hold) begin
            if (last) begin
                active_d = 1'b0;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            active_q <= active_d;
            cnt_q    <= cnt_d;
            done_q   <= active_q && !hold && last;
        end
    end

    // R3: the count never reaches the total while the access runs
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q < total_eff));
    // R3: done lasts a single cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R5/R6: a held cycle leaves the count where it was
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && hold) |=> ($stable(cnt_q) && active_q));
endmodule

// File: rtl/smc_strobe_win.sv
module smc_strobe_win
    import smc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               active_d,
    input  logic [TOTAL_W-1:0] cnt_d,
    input  win_t               win,
    output logic               on_d,
    output logic               on_q
);
    // The window is decoded from the next count so that the line itself is a flop.
    assign on_d = active_d && in_window(cnt_d, win);

    always_ff @(posedge clk) begin
        if (rst) on_q <= 1'b0;
        else     on_q <= on_d;
    end
endmodule

// File: rtl/smc_bus_seq.sv
module smc_bus_seq
    import smc_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LANES-1:0]   req_be,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               busy,
    input  logic [SETUP_W-1:0] wr_cs_setup,
    input  logic [PULSE_W-1:0] wr_cs_pulse,
    input  logic [SETUP_W-1:0] wr_st_setup,
    input  logic [PULSE_W-1:0] wr_st_pulse,
    input  logic [TOTAL_W-1:0] wr_total,
    input  logic [SETUP_W-1:0] rd_cs_setup,
    input  logic [PULSE_W-1:0] rd_cs_pulse,
    input  logic [SETUP_W-1:0] rd_st_setup,
    input  logic [PULSE_W-1:0] rd_st_pulse,
    input  logic [TOTAL_W-1:0] rd_total,
    input  logic [1:0]         wait_mode,
    input  logic               lane_style,
    input  logic               bus16,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dout,
    output logic               mem_doe,
    input  logic [DATA_W-1:0]  mem_din,
    output logic               mem_cs_n,
    output logic               mem_re_n,
    output logic               mem_we_n,
    output logic [LANES-1:0]   mem_wr_n,
    output logic [LANES-1:0]   mem_bs_n,
    input  logic               mem_wait_n
);
    localparam int BYTE_W = 8;

    // Request held for the duration of one access
    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] rdata_q;

    logic               start, hold, dir_d;
    logic               active_q, active_d, done_q;
    logic [TOTAL_W-1:0] cnt_q, cnt_d, total_sel;
    logic [NUM_CH-1:0]  on_q, on_d;
    win_t               wr_win [NUM_CH];
    win_t               rd_win [NUM_CH];
    win_t               ctl_win;
    wait_mode_e         wmode;
    logic               ready_point, freeze_on, ready_on;
    logic [LANES-1:0]   lane_mask, lanes;

    assign start     = req_valid && !active_q;
    assign dir_d     = start ? req_write : dir_q;
    assign total_sel = dir_q ? wr_total : rd_total;

    assign wr_win[CH_CS] = '{setup: wr_cs_setup, pulse: wr_cs_pulse};
    assign wr_win[CH_ST] = '{setup: wr_st_setup, pulse: wr_st_pulse};
    assign rd_win[CH_CS] = '{setup: rd_cs_setup, pulse: rd_cs_pulse};
    assign rd_win[CH_ST] = '{setup: rd_st_setup, pulse: rd_st_pulse};

    // Wait handling: freeze holds anywhere, ready holds only at the pulse end
    assign wmode       = wait_mode_e'(wait_mode);
    assign ctl_win     = dir_q ? wr_win[CH_ST] : rd_win[CH_ST];
    assign ready_point = (ctl_win.pulse != '0) &&
                         ({1'b0, cnt_q} == win_end(ctl_win) - 1'b1);
    assign freeze_on   = (wmode == WAIT_FREEZE);
    assign ready_on    = (wmode == WAIT_READY) && ready_point;
    assign hold        = active_q && !mem_wait_n && (freeze_on || ready_on);

    smc_cycle_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hold     (hold),
        .total    (total_sel),
        .active_q (active_q),
        .active_d (active_d),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .done_q   (done_q)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            smc_strobe_win u_win (
                .clk      (clk),
                .rst      (rst),
                .active_d (active_d),
                .cnt_d    (cnt_d),
                .win      (dir_d ? wr_win[ch] : rd_win[ch]),
                .on_d     (on_d[ch]),
                .on_q     (on_q[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                dir_q   <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            // Capture on the rising edge of the read strobe
            if (!dir_q && on_q[CH_ST] && !on_d[CH_ST]) begin
                rdata_q <= bus16 ? mem_din
                                 : {{(DATA_W-BYTE_W){1'b0}}, mem_din[BYTE_W-1:0]};
            end
        end
    end

    // Byte lanes: lane 0 only on the narrow bus
    assign lane_mask = bus16 ? {LANES{1'b1}} : LANES'(1);
    assign lanes     = be_q & lane_mask;

    assign mem_cs_n = !on_q[CH_CS];
    assign mem_re_n = !(on_q[CH_ST] && !dir_q);
    assign mem_we_n = !(on_q[CH_ST] && dir_q && !lane_style);

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            assign mem_wr_n[ln] = !(on_q[CH_ST] && dir_q && lane_style && lanes[ln]);
            assign mem_bs_n[ln] = !(active_q && !lane_style && lanes[ln]);
        end
    endgenerate

    assign mem_addr  = addr_q;
    assign mem_doe   = active_q && dir_q;
    assign mem_dout  = bus16 ? wdata_q
                             : {{(DATA_W-BYTE_W){1'b0}}, wdata_q[BYTE_W-1:0]};
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;
    assign busy      = active_q;

    // R1: lines are quiet outside an access
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (mem_cs_n && mem_re_n && mem_we_n && (&mem_wr_n) && !mem_doe));
    // R2: never read and write strobes at once
    assert_dir_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(!mem_re_n && (!mem_we_n || !(&mem_wr_n))));
    // R6: a low wait at the pulse end keeps the strobe asserted
    assert_ready_stretch_R6: assert property (@(posedge clk) disable iff (rst)
        (active_q && ready_on && on_q[CH_ST] && !mem_wait_n) |=> on_q[CH_ST]);
    // R4: ignore and reserved modes never hold the access
    assert_wait_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (active_q && (wmode == WAIT_IGNORE || wmode == WAIT_RSVD) && cnt_q != '0)
            |-> cnt_q == $past(cnt_q) + 1'b1);
    // R9: the upper lane stays idle on the narrow bus
    assert_upper_lane_R9: assert property (@(posedge clk) disable iff (rst)
        !bus16 |-> (mem_bs_n[1] && mem_wr_n[1]));
endmodule

// File: tb/tb_smc_bus_seq.sv
module tb_smc_bus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done, busy;
    logic [15:0] rsp_rdata;
    logic [5:0]  wr_cs_setup = '0, wr_st_setup = '0, rd_cs_setup = '0, rd_st_setup = '0;
    logic [6:0]  wr_cs_pulse = '0, wr_st_pulse = '0, rd_cs_pulse = '0, rd_st_pulse = '0;
    logic [8:0]  wr_total = 9'd1, rd_total = 9'd1;
    logic [1:0]  wait_mode = '0;
    logic        lane_style = 1'b0, bus16 = 1'b1;
    logic [23:0] mem_addr;
    logic [15:0] mem_dout, mem_din;
    logic        mem_doe, mem_cs_n, mem_re_n, mem_we_n;
    logic [1:0]  mem_wr_n, mem_bs_n;
    logic        mem_wait_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    // Memory model: returns an address-derived pattern while the read strobe is low
    assign mem_din = !mem_re_n ? {~mem_addr[7:0], mem_addr[7:0]} : 16'h0000;

    smc_bus_seq #(.ADDR_W(24)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy),
        .wr_cs_setup(wr_cs_setup), .wr_cs_pulse(wr_cs_pulse),
        .wr_st_setup(wr_st_setup), .wr_st_pulse(wr_st_pulse), .wr_total(wr_total),
        .rd_cs_setup(rd_cs_setup), .rd_cs_pulse(rd_cs_pulse),
        .rd_st_setup(rd_st_setup), .rd_st_pulse(rd_st_pulse), .rd_total(rd_total),
        .wait_mode(wait_mode), .lane_style(lane_style), .bus16(bus16),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
        .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
        .mem_wr_n(mem_wr_n), .mem_bs_n(mem_bs_n), .mem_wait_n(mem_wait_n)
    );

    typedef struct packed {
        int wr; int bw; int b16; int be;
        int cs_s; int cs_p; int st_s; int st_p; int tot;
        int mode; int ws; int wl; int exp_done;
    } vec_t;

    // wr bw b16 be | cs_s cs_p st_s st_p tot | mode ws wl | done cycle
    localparam vec_t VEC [11] = '{
        '{1, 0, 1, 3,  0,  6, 1, 4, 7,  0, 0, 0,  7},
        '{0, 0, 1, 3,  1,  5, 2, 3, 8,  0, 0, 0,  8},
        '{1, 0, 1, 1,  0, 10, 3, 9, 6,  0, 0, 0,  6},
        '{1, 1, 1, 2,  0,  8, 2, 3, 8,  2, 3, 4, 12},
        '{0, 0, 1, 3,  0,  7, 1, 3, 7,  3, 0, 8, 12},
        '{0, 1, 0, 3,  0,  7, 1, 3, 7,  3, 0, 2,  7},
        '{1, 0, 0, 3,  0,  5, 1, 2, 5,  0, 0, 9,  5},
        '{1, 1, 1, 3,  0,  5, 1, 2, 5,  1, 0, 9,  5},
        '{1, 1, 1, 3,  0,  9, 2, 4, 9,  3, 4, 5, 13},
        '{0, 0, 0, 1,  2,  3, 0, 5, 6,  2, 0, 3,  9},
        '{1, 0, 1, 3,  0,  1, 0, 1, 0,  0, 0, 0,  1}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int tot_eff(input vec_t v);
        return (v.tot == 0) ? 1 : v.tot;
    endfunction

    // Cycle at which counter value 'val' is first seen, given the wait pattern
    function automatic int ev(input int val, input vec_t v);
        int e;
        if (v.mode == 2) begin
            if (v.wl != 0 && val > v.ws) return val + v.wl;
            return val;
        end
        if (v.mode == 3 && v.st_p != 0) begin
            e = v.st_s + v.st_p;
            if (e - 1 < tot_eff(v) && e - 1 >= v.ws && e - 1 < v.ws + v.wl && val > e - 1)
                return val + (v.ws + v.wl - (e - 1));
        end
        return val;
    endfunction

    function automatic string wtag(input vec_t v);
        if (v.wl == 0) return "R2";
        if (v.mode == 2) return "R5";
        if (v.mode == 3) return "R6";
        return "R4";
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int cyc = 0;
        int csf = -1, csr = -1, stf = -1, str_ = -1, dn = -1;
        int we_seen = 0, re_seen = 0;
        logic [1:0]  wrm = '0, bsm = '0;
        logic [15:0] dout_s = '0;
        int doe_s = 0;
        logic        st_n;
        logic [23:0] a;
        logic [15:0] wd;
        int lm, bem, te, exp_rd;
        string tg;

        a  = 24'h00A001 + 24'(idx * 8);
        wd = 16'h1234 + 16'(idx * 16'h0101);
        wr_cs_setup = 6'(v.cs_s); wr_cs_pulse = 7'(v.cs_p);
        wr_st_setup = 6'(v.st_s); wr_st_pulse = 7'(v.st_p); wr_total = 9'(v.tot);
        rd_cs_setup = 6'(v.cs_s); rd_cs_pulse = 7'(v.cs_p);
        rd_st_setup = 6'(v.st_s); rd_st_pulse = 7'(v.st_p); rd_total = 9'(v.tot);
        wait_mode = 2'(v.mode); lane_style = v.bw[0]; bus16 = v.b16[0];

        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr[0]; req_addr = a;
        req_wdata = wd; req_be = 2'(v.be);
        @(negedge clk);
        req_valid = 1'b0;
        while (dn < 0 && cyc < 400) begin
            mem_wait_n = !(cyc >= v.ws && cyc < v.ws + v.wl);
            st_n = mem_we_n & mem_re_n & (&mem_wr_n);
            if (!mem_cs_n && csf < 0) csf = cyc;
            if (mem_cs_n && csf >= 0 && csr < 0) csr = cyc;
            if (!st_n && stf < 0) begin
                stf = cyc; dout_s = mem_dout; doe_s = int'(mem_doe);
            end
            if (st_n && stf >= 0 && str_ < 0) str_ = cyc;
            if (!mem_we_n) we_seen = 1;
            if (!mem_re_n) re_seen = 1;
            wrm = wrm | ~mem_wr_n;
            bsm = bsm | ~mem_bs_n;
            if (rsp_done) dn = cyc;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        mem_wait_n = 1'b1;

        te = tot_eff(v);
        tg = wtag(v);
        chk(tg, $sformatf("vec%0d cs fall", idx), csf, ev(v.cs_s, v));
        chk(tg, $sformatf("vec%0d cs rise", idx), csr, ev(imin(v.cs_s + v.cs_p, te), v));
        chk(tg, $sformatf("vec%0d strobe fall", idx), stf, ev(v.st_s, v));
        chk(tg, $sformatf("vec%0d strobe rise", idx), str_, ev(imin(v.st_s + v.st_p, te), v));
        chk(v.wl == 0 ? "R3" : tg, $sformatf("vec%0d done cycle", idx), dn, v.exp_done);
        chk("R3", $sformatf("vec%0d done vs total", idx), dn, ev(te, v));

        lm  = v.b16 != 0 ? 3 : 1;
        bem = v.be & lm;
        if (v.bw != 0) begin
            chk("R8", $sformatf("vec%0d common write strobe", idx), we_seen, 0);
            chk("R8", $sformatf("vec%0d lane write strobes", idx), int'(wrm), v.wr != 0 ? bem : 0);
            chk("R8", $sformatf("vec%0d byte selects", idx), int'(bsm), 0);
        end else begin
            chk("R7", $sformatf("vec%0d common write strobe", idx), we_seen, v.wr);
            chk("R7", $sformatf("vec%0d lane write strobes", idx), int'(wrm), 0);
            chk("R7", $sformatf("vec%0d byte selects", idx), int'(bsm), bem);
        end
        chk(v.bw != 0 ? "R8" : "R7", $sformatf("vec%0d read strobe", idx), re_seen, v.wr == 0 ? 1 : 0);
        if (v.b16 == 0)
            chk("R9", $sformatf("vec%0d upper lane", idx), int'(wrm[1] | bsm[1]), 0);

        if (v.wr != 0) begin
            chk(v.b16 != 0 ? "R10" : "R9", $sformatf("vec%0d write data", idx), int'(dout_s),
                v.b16 != 0 ? int'(wd) : int'(wd[7:0]));
            chk("R10", $sformatf("vec%0d data enable", idx), doe_s, 1);
        end else begin
            exp_rd = v.b16 != 0 ? int'({~a[7:0], a[7:0]}) : int'(a[7:0]);
            chk(v.b16 != 0 ? "R10" : "R9", $sformatf("vec%0d read data", idx), int'(rsp_rdata), exp_rd);
        end
        chk("R1", $sformatf("vec%0d idle after done", idx), int'(busy), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "cs after reset", int'(mem_cs_n), 1);
        chk("R1", "strobes after reset", int'({mem_re_n, mem_we_n, mem_wr_n}), 15);
        chk("R1", "byte selects after reset", int'(mem_bs_n), 3);
        chk("R1", "done and enable after reset", int'({rsp_done, mem_doe, busy}), 0);

        for (int i = 0; i < 11; i++) run_vec(VEC[i], i);

        // R3: a request held high over back-to-back accesses is taken again after done
        begin
            int gap = 0;
            wr_cs_setup = 6'd0; wr_cs_pulse = 7'd2; wr_st_setup = 6'd0; wr_st_pulse = 7'd2;
            wr_total = 9'd3; wait_mode = 2'b00; lane_style = 1'b0; bus16 = 1'b1;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11;
            @(negedge clk);
            while (!rsp_done && gap < 20) begin @(negedge clk); gap++; end
            chk("R3", "first access length", gap, 3);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R3", "second access started", int'(busy), 1);
            gap = 0;
            while (!rsp_done && gap < 20) begin @(negedge clk); gap++; end
            chk("R3", "second access done seen", int'(rsp_done), 1);
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule